// File: doc/BRIEF.md
# Channel Event Interrupt Coalescer

This block turns a stream of per-channel events into one host interrupt line plus an ordered list of the channels that need attention. Each event carries a channel number and a kind: transmit frame finished, receive frame finished, or an error. Software sets a per-channel enable bit. Events from enabled channels put the channel into a small first-in first-out list. Software reads the list from the head and pops entries.

The interrupt line is raised by the first listed event after the block has been armed. It then stays high, and the block stays masked, until software writes a re-arm strobe. Events that arrive while the block is masked are only appended to the list. This keeps the interrupt rate low under bursts of traffic.

A channel that is already waiting in the list is not added a second time. When the list is full, an event is lost, and this is recorded in a sticky overflow flag.

Top module: `evt_notify_mgr`

## Requirements
- R1: After reset the interrupt is low, the list is empty, overflow is low, every channel enable is 0, and the block is armed.
- R2: The event kind is 2 bits wide. Codes 0 (transmit done), 1 (receive done) and 2 (error) are reportable. Code 3 is reserved, and an event carrying it has no effect.
- R3: An event from a channel whose enable bit is 0 is neither listed nor able to raise the interrupt. The enable write port updates the bit of one channel per cycle.
- R4: When the block is armed, the first event that is listed drives the interrupt high in the cycle after the event.
- R5: Once raised, the interrupt stays high until a re-arm. Later events are only appended to the list.
- R6: An event for a channel that is already in the list is dropped as a duplicate, and the list is left unchanged.
- R7: The list is first-in first-out. The read port shows the oldest channel while list_valid is high. A pop removes that entry. A pop on an empty list has no effect.
- R8: Popping an entry frees its channel, so a later event for that channel is listed again.
- R9: On a re-arm, the interrupt is high in the next cycle if the list still holds entries. Otherwise it goes low and the block is armed again.
- R10: A reportable event that finds the list full, with no pop in the same cycle, is dropped and sets overflow. Overflow then stays set until reset.
- R11: An event that arrives together with a pop on a full list is appended, and overflow is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_chan | input | $clog2(NUM_CH) | Channel the event belongs to |
| ev_kind | input | 2 | Event kind code |
| en_wr | input | 1 | Write strobe for a channel enable bit |
| en_chan | input | $clog2(NUM_CH) | Channel whose enable bit is written |
| en_val | input | 1 | New value of that enable bit |
| rearm | input | 1 | Software re-enables the interrupt |
| pop | input | 1 | Remove the head entry of the list |
| list_valid | output | 1 | The list holds at least one entry |
| list_chan | output | $clog2(NUM_CH) | Channel at the head of the list |
| overflow | output | 1 | Sticky flag: an event was lost to a full list |
| irq | output | 1 | Host interrupt, level |

## Verification
The main function is driven with events on disabled channels, events with the reserved kind, and repeated events on a channel that is already listed. These patterns separate the three filters that can reject an event. A burst of events that arrives while the block is masked is followed by pops and re-arms, once with the list empty and once with entries left over. This tells the masking apart from the re-raise rule. Filling the list to capacity and then sending an event with a pop, and another event without one, separates the same-cycle replacement case from a real overflow. A reset in the middle of the run, while every flag is set, shows that the enables and the sticky state are cleared.

// File: rtl/evt_notify_pkg.sv
// Package: types shared by the event coalescer.
// Assumes a 2-bit event kind code; code 3 is reserved.
package evt_notify_pkg;
    typedef enum logic [1:0] {
        EVK_TX_DONE = 2'd0,
        EVK_RX_DONE = 2'd1,
        EVK_ERROR   = 2'd2,
        EVK_RSVD    = 2'd3
    } evk_e;

    // True for kinds that may be reported to software.
    function automatic logic kind_reportable(input logic [1:0] k);
        return k != EVK_RSVD;
    endfunction
endpackage

// File: rtl/evt_list_fifo.sv
// Module: circular FIFO that holds the channel numbers waiting for service.
// Assumes the caller only pushes when there is room (or a pop happens in the same cycle).
// A pop on an empty FIFO is ignored. DEPTH need not be a power of two.
module evt_list_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         nonempty_next
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULLC = CNTW'(DEPTH);

    logic [W-1:0]    mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] cnt;
    logic            pop_ok;

    assign empty  = (cnt == '0);
    assign full   = (cnt == FULLC);
    assign pop_ok = pop && !empty;
    assign dout   = mem[rd_ptr];

    // Whether the list will hold anything after this cycle's push and pop.
    assign nonempty_next = push || (cnt > CNTW'(1)) || (!empty && !pop_ok);

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push)   wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
            if (pop_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
            case ({push, pop_ok})
                2'b10:   cnt <= cnt + CNTW'(1);
                2'b01:   cnt <= cnt - CNTW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/evt_chan_state.sv
// Module: per-channel enable and pending bits.
// Assumes one enable write, one pending set and one pending clear per cycle.
// If a set and a clear hit the same channel in the same cycle, the set wins.
module evt_chan_state #(
    parameter int NUM_CH = 16,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [CW-1:0]     en_chan,
    input  logic              en_val,
    input  logic              set_vld,
    input  logic [CW-1:0]     set_chan,
    input  logic              clr_vld,
    input  logic [CW-1:0]     clr_chan,
    output logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] pend_q
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Enable bit of channel c, written by software.
        always_ff @(posedge clk) begin
            if (!rst_n)                            en_q[c] <= 1'b0;
            else if (en_wr && en_chan == CW'(c))   en_q[c] <= en_val;
        end
        // Pending bit of channel c: the channel currently sits in the list.
        always_ff @(posedge clk) begin
            if (!rst_n)                             pend_q[c] <= 1'b0;
            else if (set_vld && set_chan == CW'(c)) pend_q[c] <= 1'b1;
            else if (clr_vld && clr_chan == CW'(c)) pend_q[c] <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_irq_gate.sv
// Module: interrupt line with self-masking.
// The block is armed while irq is low. A listed event raises irq, and irq then holds
// until rearm. On rearm, irq follows whether the list will still hold entries.
module evt_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic listed,
    input  logic rearm,
    input  logic nonempty_next,
    output logic irq
);
    // Interrupt state: low means armed, high means raised and masked.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq <= 1'b0;
        else if (rearm)  irq <= nonempty_next;
        else if (listed) irq <= 1'b1;
    end
endmodule

// File: rtl/evt_notify_mgr.sv
// Module: top of the channel event interrupt coalescer.
// Filters incoming events (kind, enable, duplicate), appends accepted channels to
// the list, keeps a sticky overflow flag, and drives a self-masking interrupt.
// Assumes channel numbers at or above NUM_CH are never presented, and treats them as disabled.
module evt_notify_mgr
    import evt_notify_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int LIST_DEPTH = 8,
    localparam int CW = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    input  logic [CW-1:0] ev_chan,
    input  logic [1:0]    ev_kind,
    input  logic          en_wr,
    input  logic [CW-1:0] en_chan,
    input  logic          en_val,
    input  logic          rearm,
    input  logic          pop,
    output logic          list_valid,
    output logic [CW-1:0] list_chan,
    output logic          overflow,
    output logic          irq
);
    logic [NUM_CH-1:0] en_q, pend_q;
    logic [CW-1:0]     head;
    logic              empty, full, nonempty_next;
    logic              pop_ok, in_range, pend_eff, accept, room, push, drop;
    logic              ovf_q;

    assign pop_ok   = pop && !empty;
    assign in_range = (int'(ev_chan) < NUM_CH);

    // Event filtering. A channel that is popped in this cycle no longer counts as pending.
    always_comb begin
        pend_eff = in_range && pend_q[ev_chan] && !(pop_ok && head == ev_chan);
        accept   = ev_valid && kind_reportable(ev_kind) && in_range
                   && en_q[ev_chan] && !pend_eff;
        room     = !full || pop_ok;
        push     = accept && room;
        drop     = accept && !room;
    end

    evt_list_fifo #(.W(CW), .DEPTH(LIST_DEPTH)) list_i (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din(ev_chan), .pop(pop),
        .dout(head), .empty(empty), .full(full),
        .nonempty_next(nonempty_next)
    );

    evt_chan_state #(.NUM_CH(NUM_CH)) state_i (
        .clk(clk), .rst_n(rst_n),
        .en_wr(en_wr), .en_chan(en_chan), .en_val(en_val),
        .set_vld(push), .set_chan(ev_chan),
        .clr_vld(pop_ok), .clr_chan(head),
        .en_q(en_q), .pend_q(pend_q)
    );

    evt_irq_gate irq_i (
        .clk(clk), .rst_n(rst_n),
        .listed(push), .rearm(rearm), .nonempty_next(nonempty_next),
        .irq(irq)
    );

    // Sticky record of events lost to a full list.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_q <= 1'b0;
        else if (drop) ovf_q <= 1'b1;
    end

    assign list_valid = !empty;
    assign list_chan  = head;
    assign overflow   = ovf_q;
endmodule

// File: rtl/evt_notify_mgr_chk.sv
// Module: property checker for evt_notify_mgr, attached with bind below.
module evt_notify_mgr_chk #(
    parameter int NUM_CH = 16,
    localparam int CW = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [CW-1:0]     ev_chan,
    input logic [1:0]        ev_kind,
    input logic              rearm,
    input logic              pop,
    input logic              list_valid,
    input logic [CW-1:0]     list_chan,
    input logic              overflow,
    input logic              irq,
    input logic [NUM_CH-1:0] en_q
);
    p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> list_valid);

    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !rearm |=> irq);

    p_rsvd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid || ev_kind == 2'd3) && !list_valid |=> !list_valid);

    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !en_q[ev_chan] && !list_valid |=> !list_valid);

    p_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && list_valid && list_chan == ev_chan && !pop
        |=> list_valid && list_chan == $past(list_chan));

    p_rearm_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rearm && !list_valid && !ev_valid |=> !irq);

    p_no_overflow_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind evt_notify_mgr evt_notify_mgr_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan),
    .ev_kind(ev_kind), .rearm(rearm), .pop(pop), .list_valid(list_valid),
    .list_chan(list_chan), .overflow(overflow), .irq(irq), .en_q(en_q)
);

// File: tb/evt_notify_mgr_tb_top.sv
// Bench: a table of one-cycle vectors, then directed reset tests.
module evt_notify_mgr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int DEP = 4;
    localparam int CW  = $clog2(NCH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0, en_wr = 1'b0, en_val = 1'b0, rearm = 1'b0, pop = 1'b0;
    logic [CW-1:0] ev_chan = '0, en_chan = '0;
    logic [1:0] ev_kind = '0;
    logic list_valid, overflow, irq;
    logic [CW-1:0] list_chan;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_notify_mgr #(.NUM_CH(NCH), .LIST_DEPTH(DEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan),
        .ev_kind(ev_kind), .en_wr(en_wr), .en_chan(en_chan), .en_val(en_val),
        .rearm(rearm), .pop(pop), .list_valid(list_valid), .list_chan(list_chan),
        .overflow(overflow), .irq(irq)
    );

    typedef struct packed {
        logic       ev_v;
        logic [3:0] ev_ch;
        logic [1:0] ev_k;
        logic       en_w;
        logic [3:0] en_ch;
        logic       en_v;
        logic       rearm;
        logic       pop;
        logic       x_lv;
        logic [3:0] x_ch;
        logic       x_irq;
        logic       x_ovf;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 33;
    // Fields: ev_v ev_ch ev_k | en_w en_ch en_v | rearm pop | exp lv ch irq ovf | req
    localparam vec_t VECS [NV] = '{
        '{1'b0,4'd0,2'd0, 1'b1,4'd3,1'b1, 1'b0,1'b0, 1'b0,4'd0,1'b0,1'b0, 4'd3}, // R3 enable ch3
        '{1'b1,4'd5,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b0,4'd0,1'b0,1'b0, 4'd3}, // R3 ch5 disabled
        '{1'b0,4'd0,2'd0, 1'b1,4'd5,1'b1, 1'b0,1'b0, 1'b0,4'd0,1'b0,1'b0, 4'd3}, // R3 enable ch5
        '{1'b1,4'd3,2'd3, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b0,4'd0,1'b0,1'b0, 4'd2}, // R2 reserved kind
        '{1'b1,4'd3,2'd1, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd3,1'b1,1'b0, 4'd4}, // R4 first event
        '{1'b1,4'd3,2'd2, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd3,1'b1,1'b0, 4'd6}, // R6 duplicate
        '{1'b1,4'd5,2'd2, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd3,1'b1,1'b0, 4'd5}, // R5 masked append
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b1,4'd5,1'b1,1'b0, 4'd7}, // R7 pop
        '{1'b1,4'd3,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd5,1'b1,1'b0, 4'd8}, // R8 relist ch3
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b1,4'd3,1'b1,1'b0, 4'd8}, // R8 ch3 next
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b0,4'd0,1'b1,1'b0, 4'd7}, // R7 empty
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b0,4'd0,1'b1,1'b0, 4'd7}, // R7 pop empty
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b1,1'b0, 1'b0,4'd0,1'b0,1'b0, 4'd9}, // R9 rearm empty
        '{1'b1,4'd5,2'd1, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd5,1'b1,1'b0, 4'd4}, // R4 again
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b1,1'b0, 1'b1,4'd5,1'b1,1'b0, 4'd9}, // R9 re-raise
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b0,4'd0,1'b1,1'b0, 4'd7}, // R7
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b1,1'b0, 1'b0,4'd0,1'b0,1'b0, 4'd9}, // R9
        '{1'b0,4'd0,2'd0, 1'b1,4'd0,1'b1, 1'b0,1'b0, 1'b0,4'd0,1'b0,1'b0, 4'd3}, // R3 enable ch0
        '{1'b0,4'd0,2'd0, 1'b1,4'd1,1'b1, 1'b0,1'b0, 1'b0,4'd0,1'b0,1'b0, 4'd3}, // R3 enable ch1
        '{1'b0,4'd0,2'd0, 1'b1,4'd2,1'b1, 1'b0,1'b0, 1'b0,4'd0,1'b0,1'b0, 4'd3}, // R3 enable ch2
        '{1'b1,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd0,1'b1,1'b0, 4'd4}, // R4
        '{1'b1,4'd1,2'd1, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd0,1'b1,1'b0, 4'd7}, // R7 fill
        '{1'b1,4'd2,2'd2, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd0,1'b1,1'b0, 4'd7}, // R7 fill
        '{1'b1,4'd3,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd0,1'b1,1'b0, 4'd7}, // R7 full
        '{1'b1,4'd5,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b1,4'd1,1'b1,1'b0, 4'd11},// R11 push+pop full
        '{1'b1,4'd0,2'd1, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd1,1'b1,1'b1, 4'd10},// R10 overflow
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b1,4'd2,1'b1,1'b1, 4'd10},// R10 sticky
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b1,4'd3,1'b1,1'b1, 4'd7}, // R7 order
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b1,4'd5,1'b1,1'b1, 4'd11},// R11 ch5 kept
        '{1'b0,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b1, 1'b0,4'd0,1'b1,1'b1, 4'd10},// R10 ch0 lost
        '{1'b1,4'd0,2'd2, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b1,4'd0,1'b1,1'b1, 4'd10},// R10 ch0 listable
        '{1'b0,4'd0,2'd0, 1'b1,4'd0,1'b0, 1'b0,1'b1, 1'b0,4'd0,1'b1,1'b1, 4'd3}, // R3 disable ch0
        '{1'b1,4'd0,2'd0, 1'b0,4'd0,1'b0, 1'b0,1'b0, 1'b0,4'd0,1'b1,1'b1, 4'd3}  // R3 ignored
    };

    task automatic check(input string what, input int req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ev_valid = 1'b0; en_wr = 1'b0; rearm = 1'b0; pop = 1'b0;
        ev_chan = '0; ev_kind = '0; en_chan = '0; en_val = 1'b0;
    endtask

    task automatic check_idle_state(input int req);
        check("irq", req, int'(irq), 0);
        check("list_valid", req, int'(list_valid), 0);
        check("overflow", req, int'(overflow), 0);
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: state while and after reset
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_state(1);

        for (int i = 0; i < NV; i++) begin
            ev_valid = VECS[i].ev_v;  ev_chan = VECS[i].ev_ch; ev_kind = VECS[i].ev_k;
            en_wr    = VECS[i].en_w;  en_chan = VECS[i].en_ch; en_val  = VECS[i].en_v;
            rearm    = VECS[i].rearm; pop     = VECS[i].pop;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("vec%0d list_valid", i), int'(VECS[i].req), int'(list_valid), int'(VECS[i].x_lv));
            check($sformatf("vec%0d irq", i), int'(VECS[i].req), int'(irq), int'(VECS[i].x_irq));
            check($sformatf("vec%0d overflow", i), int'(VECS[i].req), int'(overflow), int'(VECS[i].x_ovf));
            if (VECS[i].x_lv)
                check($sformatf("vec%0d list_chan", i), int'(VECS[i].req), int'(list_chan), int'(VECS[i].x_ch));
        end

        // R1: a reset in mid-run clears irq, overflow and the list
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_idle_state(1);
        // R1: enables are cleared by reset, so ch3 (enabled before) is ignored
        ev_valid = 1'b1; ev_chan = 4'd3; ev_kind = 2'd0;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check_idle_state(1);
        // R1: the block is armed after reset, so a listed event raises irq
        en_wr = 1'b1; en_chan = 4'd9; en_val = 1'b1;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        ev_valid = 1'b1; ev_chan = 4'd9; ev_kind = 2'd2;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check("irq after reset arm", 1, int'(irq), 1);
        check("list_chan after reset", 1, int'(list_chan), 9);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule